// File: doc/BRIEF.md
# Shadow Memory Access Checker

This unit sits beside a load/store path and decides, for each memory access, whether the bytes touched are legal according to a shadow map. Each group of eight application bytes (a granule) has one shadow byte. For an access the unit computes the shadow location as the address shifted right by the scale (3) plus a loadable base. It reads that one byte through a simple read port and classifies it. If the shadow byte is zero, the whole granule is usable. If its top bit is set, the whole granule is poisoned (redzones, freed memory and so on). A small positive value k means that only the leading k bytes of the granule may be touched.

Addresses that fall inside a configurable forbidden window are flagged at once and no shadow read is made. That window is where the shadow of the shadow region itself lands. Each request produces one result pulse. The pulse carries the verdict, the original address and size, and the shadow byte that decided it. The shadow base and the window bounds sit in three writable configuration registers. Accesses are assumed to stay within one granule.

Top module: `shadow_chk`

## Requirements
- R1: After reset, req_ready is 1, and res_valid and shd_rd_en are 0.
- R2: A request is accepted on a clock edge where req_valid and req_ready are both 1. For an address outside the forbidden window, shd_rd_en is 1 for exactly the following cycle, with shd_rd_addr = (address >> 3) + shadow base, modulo 2^AW. The base resets to 0x7000020000.
- R3: res_valid pulses for exactly one cycle, in the cycle after the one in which shd_rd_valid is sampled high. The pulse carries res_addr and res_size equal to the accepted request and res_shadow equal to the byte returned.
- R4: A shadow byte of 0x00 yields res_ok = 1 for every size and alignment.
- R5: req_size encodes 1, 2, 4 or 8 bytes as 0, 1, 2, 3. For a shadow byte from 0x01 to 0x7F, res_ok = 1 exactly when address[2:0] + bytes - 1 is less than the shadow byte.
- R6: A shadow byte with bit 7 set always yields res_ok = 0.
- R7: An address A with gap_lo <= A <= gap_hi issues no shadow read. Its result follows two cycles after acceptance, with res_ok = 0 and res_shadow = 0xCC. The reset bounds are gap_lo = base + (base >> 3) and gap_hi = base + ((base + 2^45 - 1) >> 3).
- R8: A one-cycle cfg_we writes cfg_wdata to the register picked by cfg_sel: 0 is the shadow base, 1 is gap_lo, 2 is gap_hi. cfg_sel = 3 changes nothing. Later requests use the new values.
- R9: req_ready is 0 from the cycle after acceptance through the result cycle, and 1 again in the cycle after. A req_valid raised while req_ready is 0 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Unit idle, request may be accepted |
| req_addr | input | AW | Application address of the access |
| req_size | input | 2 | log2 of access size in bytes |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Configuration register select |
| cfg_wdata | input | AW | Configuration write value |
| shd_rd_en | output | 1 | Shadow byte read strobe |
| shd_rd_addr | output | AW | Shadow byte address |
| shd_rd_valid | input | 1 | Shadow read data present |
| shd_rd_data | input | 8 | Shadow byte returned |
| res_valid | output | 1 | One-cycle result strobe |
| res_ok | output | 1 | 1 = access allowed, 0 = violation |
| res_addr | output | AW | Address of the checked access |
| res_size | output | 2 | Size code of the checked access |
| res_shadow | output | 8 | Shadow byte that decided the result (0xCC for window hits) |

## Verification
Some properties are checked by assertions on every cycle. A shadow read only ever follows an acceptance, the result strobe is never two cycles long, and the unit goes busy after each acceptance. Every result echoes the address that was accepted. A zero shadow byte never gives a violation and a byte with bit 7 set always does. The rest needs the bench's scenarios. These are the exact partial-granule boundary for every size, alignment and shadow value, and the computed shadow address under the reset base and a reloaded one. They also cover both edges of the forbidden window, with its missing read, and the effect of each configuration select. Finally, a request raised while the unit is busy must be ignored.

// File: rtl/shadow_chk_pkg.sv
package shadow_chk_pkg;
   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_ISSUE  = 2'd1,
      ST_WAIT   = 2'd2,
      ST_REPORT = 2'd3
   } chk_state_e;

   typedef enum logic [1:0] {
      CFG_BASE   = 2'd0,
      CFG_GAP_LO = 2'd1,
      CFG_GAP_HI = 2'd2,
      CFG_NONE   = 2'd3
   } cfg_sel_e;

   localparam logic [7:0] GAP_CODE = 8'hCC;
endpackage

// File: rtl/shadow_chk_cfg.sv
module shadow_chk_cfg
   import shadow_chk_pkg::*;
#(
   parameter int unsigned   AW     = 48,
   parameter logic [AW-1:0] DEF_BASE = '0,
   parameter logic [AW-1:0] DEF_LO   = '0,
   parameter logic [AW-1:0] DEF_HI   = '0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [1:0]    sel,
   input  logic [AW-1:0] wdata,
   output logic [AW-1:0] base,
   output logic [AW-1:0] gap_lo,
   output logic [AW-1:0] gap_hi
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base   <= DEF_BASE;
         gap_lo <= DEF_LO;
         gap_hi <= DEF_HI;
      end else if (we) begin
         case (cfg_sel_e'(sel))
            CFG_BASE:   base   <= wdata;
            CFG_GAP_LO: gap_lo <= wdata;
            CFG_GAP_HI: gap_hi <= wdata;
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/shadow_chk_map.sv
module shadow_chk_map #(
   parameter int unsigned AW     = 48,
   parameter int unsigned SCALE  = 3,
   parameter bit          GAP_EN = 1'b1
) (
   input  logic [AW-1:0] addr,
   input  logic [AW-1:0] base,
   input  logic [AW-1:0] gap_lo,
   input  logic [AW-1:0] gap_hi,
   output logic [AW-1:0] shd_addr,
   output logic          in_gap
);
   assign shd_addr = (addr >> SCALE) + base;

   generate
      if (GAP_EN) begin : g_gap
         assign in_gap = (addr >= gap_lo) && (addr <= gap_hi);
      end else begin : g_nogap
         assign in_gap = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/shadow_chk_decode.sv
module shadow_chk_decode #(
   parameter int unsigned SCALE = 3
) (
   input  logic [SCALE-1:0] lo,
   input  logic [1:0]       size,
   input  logic [7:0]       shadow,
   output logic             ok
);
   localparam int unsigned LW = SCALE + 2;

   logic [LW-1:0] last_idx;
   logic [7:0]    last8;

   assign last_idx = LW'(lo) + (LW'(1) << size) - LW'(1);
   assign last8    = 8'(last_idx);

   always_comb begin
      if (shadow == 8'h00)  ok = 1'b1;
      else if (shadow[7])   ok = 1'b0;
      else                  ok = (last8 < shadow);
   end
endmodule

// File: rtl/shadow_chk.sv
module shadow_chk
   import shadow_chk_pkg::*;
#(
   parameter int unsigned   AW           = 48,
   parameter int unsigned   SCALE        = 3,
   parameter logic [AW-1:0] SHADOW_BASE  = AW'(64'h70_0002_0000),
   parameter bit            GAP_CHECK_EN = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   output logic          req_ready,
   input  logic [AW-1:0] req_addr,
   input  logic [1:0]    req_size,
   input  logic          cfg_we,
   input  logic [1:0]    cfg_sel,
   input  logic [AW-1:0] cfg_wdata,
   output logic          shd_rd_en,
   output logic [AW-1:0] shd_rd_addr,
   input  logic          shd_rd_valid,
   input  logic [7:0]    shd_rd_data,
   output logic          res_valid,
   output logic          res_ok,
   output logic [AW-1:0] res_addr,
   output logic [1:0]    res_size,
   output logic [7:0]    res_shadow
);
   localparam logic [AW-1:0] SPAN_M1 = {{SCALE{1'b0}}, {(AW-SCALE){1'b1}}};
   localparam logic [AW-1:0] DEF_LO  = SHADOW_BASE + (SHADOW_BASE >> SCALE);
   localparam logic [AW-1:0] DEF_HI  = SHADOW_BASE + ((SHADOW_BASE + SPAN_M1) >> SCALE);

   if (SCALE < 1 || SCALE > 6) begin : g_bad_scale
      $error("shadow_chk: SCALE must lie in 1..6");
   end
   if (AW <= SCALE + 2) begin : g_bad_aw
      $error("shadow_chk: AW too small for SCALE");
   end

   chk_state_e    state_q;
   logic [AW-1:0] addr_q;
   logic [1:0]    size_q;
   logic [7:0]    shd_q;
   logic          ok_q;

   logic [AW-1:0] base, gap_lo, gap_hi, map_addr;
   logic          in_gap, dec_ok;

   shadow_chk_cfg #(
      .AW(AW), .DEF_BASE(SHADOW_BASE), .DEF_LO(DEF_LO), .DEF_HI(DEF_HI)
   ) u_cfg (
      .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
      .base(base), .gap_lo(gap_lo), .gap_hi(gap_hi)
   );

   shadow_chk_map #(
      .AW(AW), .SCALE(SCALE), .GAP_EN(GAP_CHECK_EN)
   ) u_map (
      .addr(addr_q), .base(base), .gap_lo(gap_lo), .gap_hi(gap_hi),
      .shd_addr(map_addr), .in_gap(in_gap)
   );

   shadow_chk_decode #(
      .SCALE(SCALE)
   ) u_dec (
      .lo(addr_q[SCALE-1:0]), .size(size_q), .shadow(shd_rd_data), .ok(dec_ok)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         addr_q  <= '0;
         size_q  <= '0;
         shd_q   <= '0;
         ok_q    <= 1'b0;
      end else begin
         case (state_q)
            ST_IDLE: if (req_valid) begin
               addr_q  <= req_addr;
               size_q  <= req_size;
               state_q <= ST_ISSUE;
            end
            ST_ISSUE: if (in_gap) begin
               shd_q   <= GAP_CODE;
               ok_q    <= 1'b0;
               state_q <= ST_REPORT;
            end else begin
               state_q <= ST_WAIT;
            end
            ST_WAIT: if (shd_rd_valid) begin
               shd_q   <= shd_rd_data;
               ok_q    <= dec_ok;
               state_q <= ST_REPORT;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign req_ready   = (state_q == ST_IDLE);
   assign shd_rd_en   = (state_q == ST_ISSUE) && !in_gap;
   assign shd_rd_addr = map_addr;
   assign res_valid   = (state_q == ST_REPORT);
   assign res_ok      = ok_q;
   assign res_addr    = addr_q;
   assign res_size    = size_q;
   assign res_shadow  = shd_q;
endmodule

// File: rtl/shadow_chk_checker.sv
module shadow_chk_checker #(
   parameter int unsigned AW = 48
) (
   input logic          clk,
   input logic          rst_n,
   input logic          req_valid,
   input logic          req_ready,
   input logic [AW-1:0] req_addr,
   input logic          shd_rd_en,
   input logic          res_valid,
   input logic          res_ok,
   input logic [AW-1:0] res_addr,
   input logic [7:0]    res_shadow
);
   logic [AW-1:0] seen_addr;

   always_ff @(posedge clk) begin
      if (!rst_n)                      seen_addr <= '0;
      else if (req_valid && req_ready) seen_addr <= req_addr;
   end

   p_rd_after_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
      shd_rd_en |-> $past(req_valid && req_ready));

   p_single_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |=> !res_valid);

   p_addr_echo_r3: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> (res_addr == seen_addr));

   p_zero_ok_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && res_shadow == 8'h00) |-> res_ok);

   p_poison_bad_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && res_shadow[7]) |-> !res_ok);

   p_busy_after_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);
endmodule

bind shadow_chk shadow_chk_checker #(.AW(AW)) u_shadow_chk_checker (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
   .req_addr(req_addr), .shd_rd_en(shd_rd_en), .res_valid(res_valid),
   .res_ok(res_ok), .res_addr(res_addr), .res_shadow(res_shadow)
);

// File: tb/shadow_chk_bench.sv
module shadow_chk_bench;
   localparam int AW = 48;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_ready;
   logic [AW-1:0] req_addr = '0;
   logic [1:0]    req_size = '0;
   logic          cfg_we = 1'b0;
   logic [1:0]    cfg_sel = '0;
   logic [AW-1:0] cfg_wdata = '0;
   logic          shd_rd_en;
   logic [AW-1:0] shd_rd_addr;
   logic          shd_rd_valid = 1'b0;
   logic [7:0]    shd_rd_data = '0;
   logic          res_valid, res_ok;
   logic [AW-1:0] res_addr;
   logic [1:0]    res_size;
   logic [7:0]    res_shadow;

   int n_checks = 0;
   int n_fail   = 0;
   longint unsigned cur_base = 64'h70_0002_0000;
   logic [AW-1:0] ignored_addr = '0;

   always #10 clk = ~clk;

   shadow_chk u_shadow_chk (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_addr(req_addr), .req_size(req_size), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
      .cfg_wdata(cfg_wdata), .shd_rd_en(shd_rd_en), .shd_rd_addr(shd_rd_addr),
      .shd_rd_valid(shd_rd_valid), .shd_rd_data(shd_rd_data), .res_valid(res_valid),
      .res_ok(res_ok), .res_addr(res_addr), .res_size(res_size), .res_shadow(res_shadow)
   );

   task automatic chk(input bit cond, input string tag, input longint unsigned act,
                      input longint unsigned exp);
      n_checks++;
      if (!cond) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   function automatic bit exp_ok(input int lo, input int sz, input int sh);
      if (sh == 0) return 1'b1;
      if (sh >= 128) return 1'b0;
      return (lo + (1 << sz) - 1) < sh;
   endfunction

   task automatic cfg_write(input logic [1:0] sel, input logic [AW-1:0] val);
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = val;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   // Normal access with a shadow read; lat >= 1 cycles before data returns.
   task automatic access(input logic [AW-1:0] a, input logic [1:0] sz,
                         input logic [7:0] sh, input int lat, input bit poke);
      logic [AW-1:0] exp_sa;
      bit eok;
      exp_sa = AW'((longint'(a) >> 3) + cur_base);
      eok = exp_ok(int'(a[2:0]), int'(sz), int'(sh));
      @(negedge clk);
      req_valid = 1'b1; req_addr = a; req_size = sz;
      @(negedge clk);
      req_valid = 1'b0;
      chk(shd_rd_en == 1'b1, "R2 read strobe", shd_rd_en, 1);
      chk(shd_rd_addr == exp_sa, "R2 shadow address", shd_rd_addr, exp_sa);
      for (int i = 0; i < lat; i++) begin
         @(negedge clk);
         if (poke) begin
            req_valid = 1'b1; req_addr = ignored_addr;
         end
      end
      chk(shd_rd_en == 1'b0, "R2 single read", shd_rd_en, 0);
      chk(req_ready == 1'b0, "R9 busy while waiting", req_ready, 0);
      shd_rd_valid = 1'b1; shd_rd_data = sh;
      @(negedge clk);
      shd_rd_valid = 1'b0;
      chk(res_valid == 1'b1, "R3 result pulse", res_valid, 1);
      chk(res_ok == eok, (sh == 0) ? "R4 zero shadow" : (sh[7] ? "R6 poisoned" : "R5 partial"),
          res_ok, eok);
      chk(res_addr == a, "R3 address echo", res_addr, a);
      chk(res_size == sz, "R3 size echo", res_size, sz);
      chk(res_shadow == sh, "R3 shadow echo", res_shadow, sh);
      chk(req_ready == 1'b0, "R9 busy in result cycle", req_ready, 0);
      if (poke) begin
         @(posedge clk);
         req_valid = 1'b0;
      end
      @(negedge clk);
      chk(res_valid == 1'b0, "R3 pulse width", res_valid, 0);
      chk(req_ready == 1'b1, "R9 ready again", req_ready, 1);
   endtask

   // Access expected to land in the forbidden window (R7).
   task automatic gap_access(input logic [AW-1:0] a);
      @(negedge clk);
      req_valid = 1'b1; req_addr = a; req_size = 2'd0;
      @(negedge clk);
      req_valid = 1'b0;
      chk(shd_rd_en == 1'b0, "R7 no shadow read", shd_rd_en, 0);
      chk(res_valid == 1'b0, "R7 no early result", res_valid, 0);
      @(negedge clk);
      chk(res_valid == 1'b1, "R7 result timing", res_valid, 1);
      chk(res_ok == 1'b0, "R7 violation", res_ok, 0);
      chk(res_shadow == 8'hCC, "R7 gap code", res_shadow, 8'hCC);
      chk(res_addr == a, "R7 address echo", res_addr, a);
      @(negedge clk);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin : main
      int shv [20] = '{0, 1, 2, 3, 4, 5, 6, 7, 8, 'h7f, 'h80, 'hf1, 'hf2, 'hf3,
                       'hf5, 'hf8, 'hf9, 'hfa, 'hfd, 'hff};
      longint unsigned glo, ghi;
      int t;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);
      chk(res_valid == 1'b0, "R1 no result after reset", res_valid, 0);
      chk(shd_rd_en == 1'b0, "R1 no read after reset", shd_rd_en, 0);

      // R4 R5 R6 sweep over size, alignment and shadow value
      t = 0;
      for (int sz = 0; sz < 4; sz++)
         for (int lo = 0; lo < 8; lo++)
            for (int k = 0; k < 20; k++) begin
               access(AW'(64'h1234_5670 + longint'(t) * 8 + lo), 2'(sz), 8'(shv[k]),
                      (t % 3) + 1, 1'b0);
               t++;
            end

      // R9 request raised while busy is ignored
      ignored_addr = AW'(64'h0BAD_0000);
      access(AW'(64'h2222_0003), 2'd0, 8'h04, 2, 1'b1);
      @(negedge clk);
      chk(shd_rd_en == 1'b0, "R9 ignored request issued no read", shd_rd_en, 0);

      // R7 reset window bounds
      glo = cur_base + (cur_base >> 3);
      ghi = cur_base + ((cur_base + (64'd1 << 45) - 1) >> 3);
      gap_access(AW'(glo));
      gap_access(AW'(ghi));
      access(AW'(glo - 1), 2'd0, 8'h00, 1, 1'b0);
      access(AW'(ghi + 1), 2'd0, 8'h00, 1, 1'b0);

      // R8 reload base, window; select 3 has no effect
      cur_base = 64'h1000;
      cfg_write(2'd0, AW'(cur_base));
      access(AW'(64'h8000), 2'd2, 8'h00, 1, 1'b0);
      cfg_write(2'd3, AW'(64'hDEAD_0000));
      access(AW'(64'h8008), 2'd1, 8'h02, 1, 1'b0);
      cfg_write(2'd1, AW'(64'h500));
      cfg_write(2'd2, AW'(64'h50F));
      gap_access(AW'(64'h500));
      gap_access(AW'(64'h50F));
      access(AW'(64'h4FF), 2'd0, 8'h00, 1, 1'b0);
      access(AW'(64'h510), 2'd0, 8'h00, 1, 1'b0);
      access(AW'(glo), 2'd3, 8'h00, 1, 1'b0);

      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule